// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block keeps a small store of recently used virtual-to-physical page translations. A lookup presents a full virtual address. The block returns hit or miss in the same cycle, and on a hit it also returns the physical address. Only the page number is translated. The low 12 address bits, the byte position inside a 4 KiB page, go around the store untouched and are appended to the stored frame number.

The store holds 64 entries in 16 sets of 4 ways. Virtual address bits 15:12 select a set. The remaining upper page-number bits form the tag, which is compared against every way of that set at once. A miss tells the surrounding logic to start a page table walk. When the walk finishes, the result is installed through the fill port. Within each set a true least-recently-used order picks the victim, and hits and fills both count as uses. A flush input drops every entry in a single cycle.

Top module: `xlat_cache`

## Requirements
- R1: A valid lookup whose page number is stored raises lkHit in the same cycle. lkPa then carries the stored frame number in bits 31:12.
- R2: On a hit, lkPa bits 11:0 equal lkVa bits 11:0 unchanged.
- R3: A valid lookup with no matching entry raises lkMiss and keeps lkHit low. While lkValid is low, both lkHit and lkMiss stay low.
- R4: Virtual address bits 15:12 pick one of 16 sets. Four translations with different tags in one set are all retained, and fills to another set do not disturb them.
- R5: A fill into a set that still has an invalid way uses that way and evicts nothing.
- R6: A fill into a full set replaces the way that was least recently hit or filled.
- R7: A fill whose page number is already stored overwrites that entry's frame number and occupies no second way.
- R8: flush invalidates every entry in one cycle. A lookup in the same cycle as flush reports a miss.
- R9: A fill presented in the same cycle as flush is discarded.
- R10: A lookup in the same cycle as a fill sees the contents from before that fill. The filled translation is visible from the next cycle on.
- R11: After reset, every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all entries |
| lkValid | input | 1 | Lookup request qualifier |
| lkVa | input | 32 | Lookup virtual address |
| lkHit | output | 1 | Lookup found a translation |
| lkMiss | output | 1 | Lookup found none; a walk is needed |
| lkPa | output | 32 | Physical address, meaningful on hit |
| fillValid | input | 1 | Install a translation |
| fillVpn | input | 20 | Virtual page number to install |
| fillPfn | input | 20 | Physical frame number to install |

## Verification
A lookup and a fill can land in the same cycle, and so can a lookup and a flush. The bench provokes both. It drives a lookup for the very page that is being filled in that cycle and expects a miss, then expects a hit with the new frame on the next cycle. It also drives a flush alongside a lookup of a page that is present and expects a miss. A fill paired with a flush is judged by a lookup on the next cycle, which must miss.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // Strobes from the replacement control to the entry store.
  typedef struct packed {
    logic clearAll;
    logic writeEn;
  } xlat_strobe_t;
endpackage

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int TAG_W = 16,
  parameter int PFN_W = 20
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  xlat_strobe_t             strobe,
  input  logic [$clog2(SETS)-1:0]  lkIdx,
  input  logic [TAG_W-1:0]         lkTag,
  input  logic [$clog2(SETS)-1:0]  fillIdx,
  input  logic [TAG_W-1:0]         fillTag,
  input  logic [PFN_W-1:0]         fillPfn,
  input  logic [$clog2(WAYS)-1:0]  wrWay,
  output logic [WAYS-1:0]          lkHitVec,
  output logic [PFN_W-1:0]         lkPfn,
  output logic [WAYS-1:0]          fillMatchVec,
  output logic [WAYS-1:0]          fillValidVec
);
  logic [SETS-1:0][WAYS-1:0]            validQ;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tagQ;
  logic [SETS-1:0][WAYS-1:0][PFN_W-1:0] pfnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (strobe.clearAll) begin
      validQ <= '0;
    end else if (strobe.writeEn) begin
      validQ[fillIdx][wrWay] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.writeEn) begin
      tagQ[fillIdx][wrWay] <= fillTag;
      pfnQ[fillIdx][wrWay] <= fillPfn;
    end
  end

  // Parallel compare of every way in both addressed sets
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign lkHitVec[w]     = validQ[lkIdx][w] && (tagQ[lkIdx][w] == lkTag);
    assign fillMatchVec[w] = validQ[fillIdx][w] && (tagQ[fillIdx][w] == fillTag);
    assign fillValidVec[w] = validQ[fillIdx][w];
  end

  always_comb begin
    lkPfn = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lkHitVec[w]) lkPfn = lkPfn | pfnQ[lkIdx][w];
    end
  end
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru
  import xlat_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     flush,
  input  logic                     lkValid,
  input  logic [$clog2(SETS)-1:0]  lkIdx,
  input  logic [WAYS-1:0]          lkHitVec,
  input  logic                     fillValid,
  input  logic [$clog2(SETS)-1:0]  fillIdx,
  input  logic [WAYS-1:0]          fillMatchVec,
  input  logic [WAYS-1:0]          fillValidVec,
  output xlat_strobe_t             strobe,
  output logic [$clog2(WAYS)-1:0]  wrWay
);
  localparam int WAY_W = $clog2(WAYS);
  typedef logic [WAYS-1:0][WAY_W-1:0] ageSet_t;

  // Age 0 = most recent, WAYS-1 = least recent; each set holds a permutation.
  ageSet_t [SETS-1:0] ageQ;
  ageSet_t [SETS-1:0] ageD;

  function automatic ageSet_t touch(input ageSet_t a, input logic [WAY_W-1:0] w);
    ageSet_t r;
    for (int i = 0; i < WAYS; i++) begin
      if (WAY_W'(i) == w)      r[i] = '0;
      else if (a[i] < a[w])    r[i] = a[i] + 1'b1;
      else                     r[i] = a[i];
    end
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] firstSet(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (v[i]) r = WAY_W'(i);
    end
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] oldest(input ageSet_t a);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (a[i] == WAY_W'(WAYS - 1)) r = WAY_W'(i);
    end
    return r;
  endfunction

  logic             hitTouch;
  logic [WAY_W-1:0] hitWay;
  logic             anyMatch;
  logic             anyFree;

  assign hitTouch = lkValid && (|lkHitVec) && !flush;
  assign hitWay   = firstSet(lkHitVec);
  assign anyMatch = |fillMatchVec;
  assign anyFree  = ~&fillValidVec;

  always_comb begin
    if (anyMatch)     wrWay = firstSet(fillMatchVec);
    else if (anyFree) wrWay = firstSet(~fillValidVec);
    else              wrWay = oldest(ageQ[fillIdx]);
  end

  assign strobe.clearAll = flush;
  assign strobe.writeEn  = fillValid && !flush;

  // Hit applied first, then the fill on top (same set or not)
  always_comb begin
    ageD = ageQ;
    if (hitTouch)       ageD[lkIdx]   = touch(ageQ[lkIdx], hitWay);
    if (strobe.writeEn) ageD[fillIdx] = touch(ageD[fillIdx], wrWay);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int i = 0; i < WAYS; i++) begin
          ageQ[s][i] <= WAY_W'(i);
        end
      end
    end else begin
      ageQ <= ageD;
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 64,
  parameter int WAYS    = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  flush,
  input  logic                  lkValid,
  input  logic [VA_W-1:0]       lkVa,
  output logic                  lkHit,
  output logic                  lkMiss,
  output logic [PA_W-1:0]       lkPa,
  input  logic                  fillValid,
  input  logic [VA_W-OFF_W-1:0] fillVpn,
  input  logic [PA_W-OFF_W-1:0] fillPfn
);
  localparam int SETS  = ENTRIES / WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int PFN_W = PA_W - OFF_W;

  xlat_strobe_t     strobe;
  logic [WAY_W-1:0] wrWay;
  logic [WAYS-1:0]  lkHitVec, fillMatchVec, fillValidVec;
  logic [PFN_W-1:0] lkPfn;
  logic [IDX_W-1:0] lkIdx, fillIdx;
  logic [TAG_W-1:0] lkTag, fillTag;

  assign lkIdx   = lkVa[OFF_W +: IDX_W];
  assign lkTag   = lkVa[VA_W-1 -: TAG_W];
  assign fillIdx = fillVpn[IDX_W-1:0];
  assign fillTag = fillVpn[VPN_W-1 -: TAG_W];

  xlat_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .PFN_W(PFN_W)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lkIdx(lkIdx), .lkTag(lkTag),
    .fillIdx(fillIdx), .fillTag(fillTag), .fillPfn(fillPfn), .wrWay(wrWay),
    .lkHitVec(lkHitVec), .lkPfn(lkPfn),
    .fillMatchVec(fillMatchVec), .fillValidVec(fillValidVec)
  );

  xlat_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk(clk), .rstN(rstN), .flush(flush),
    .lkValid(lkValid), .lkIdx(lkIdx), .lkHitVec(lkHitVec),
    .fillValid(fillValid), .fillIdx(fillIdx),
    .fillMatchVec(fillMatchVec), .fillValidVec(fillValidVec),
    .strobe(strobe), .wrWay(wrWay)
  );

  assign lkHit  = lkValid && (|lkHitVec) && !flush;
  assign lkMiss = lkValid && !lkHit;
  assign lkPa   = {lkPfn, lkVa[OFF_W-1:0]};
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  flush,
  input logic                  lkValid,
  input logic [VA_W-1:0]       lkVa,
  input logic                  lkHit,
  input logic                  lkMiss,
  input logic [PA_W-1:0]       lkPa,
  input logic                  fillValid,
  input logic [VA_W-OFF_W-1:0] fillVpn,
  input logic [PA_W-OFF_W-1:0] fillPfn
);
  // R2
  pa_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> lkPa[OFF_W-1:0] == lkVa[OFF_W-1:0]);

  // R3
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |-> (lkHit ^ lkMiss));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |-> (!lkHit && !lkMiss));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !lkHit);

  // R10
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !flush) |=>
      (!lkValid || flush || lkVa[VA_W-1:OFF_W] != $past(fillVpn) ||
       (lkHit && lkPa[PA_W-1:OFF_W] == $past(fillPfn))));
endmodule

bind xlat_cache xlat_cache_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rstN(rstN), .flush(flush), .lkValid(lkValid), .lkVa(lkVa),
  .lkHit(lkHit), .lkMiss(lkMiss), .lkPa(lkPa),
  .fillValid(fillValid), .fillVpn(fillVpn), .fillPfn(fillPfn)
);

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        lkValid = 1'b0;
  logic [31:0] lkVa = '0;
  logic        lkHit, lkMiss;
  logic [31:0] lkPa;
  logic        fillValid = 1'b0;
  logic [19:0] fillVpn = '0;
  logic [19:0] fillPfn = '0;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          hit;
    logic [31:0] pa;
    string       req;
  } expect_t;
  expect_t sbQ[$];

  always #4 clk = ~clk;

  xlat_cache dut (
    .clk(clk), .rstN(rstN), .flush(flush), .lkValid(lkValid), .lkVa(lkVa),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkPa(lkPa),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPfn(fillPfn)
  );

  task automatic drive(input bit lv, input logic [31:0] va, input bit fv,
                       input logic [19:0] vpn, input logic [19:0] pfn, input bit fl,
                       input bit eh, input logic [31:0] epa, input string req);
    expect_t e;
    @(negedge clk);
    lkValid = lv; lkVa = va; fillValid = fv; fillVpn = vpn; fillPfn = pfn; flush = fl;
    if (lv) begin
      e.hit = eh; e.pa = epa; e.req = req;
      sbQ.push_back(e);
    end
  endtask

  task automatic look(input logic [31:0] va, input bit eh, input logic [31:0] epa, input string req);
    drive(1'b1, va, 1'b0, '0, '0, 1'b0, eh, epa, req);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn);
    drive(1'b0, '0, 1'b1, vpn, pfn, 1'b0, 1'b0, '0, "");
  endtask

  // Monitor: compare each lookup result against the scoreboard
  always @(negedge clk) begin
    expect_t e;
    #2;
    if (sbQ.size() > 0) begin
      e = sbQ.pop_front();
      testsRun++;
      if (lkHit !== e.hit || lkMiss !== !e.hit || (e.hit && lkPa !== e.pa)) begin
        testsFailed++;
        $display("FAIL %s: hit=%0b miss=%0b pa=%h expected hit=%0b pa=%h",
                 e.req, lkHit, lkMiss, lkPa, e.hit, e.pa);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R3: idle outputs quiet
    testsRun++;
    if (lkHit !== 1'b0 || lkMiss !== 1'b0) begin
      testsFailed++;
      $display("FAIL R3: idle hit=%0b miss=%0b expected 0 0", lkHit, lkMiss);
    end
    rstN = 1'b1;

    look(32'h0001_1234, 0, '0, "R11");                    // empty after reset
    fill(20'h00011, 20'hAAAAA);
    look(32'h0001_1ABC, 1, 32'hAAAA_AABC, "R1");
    look(32'h0001_1FFF, 1, 32'hAAAA_AFFF, "R2");
    look(32'h0001_2ABC, 0, '0, "R3");                     // other set, miss
    // R10: lookup and fill of the same page in one cycle
    drive(1'b1, 32'h0002_1010, 1'b1, 20'h00021, 20'hBBBBB, 1'b0, 0, '0, "R10");
    look(32'h0002_1010, 1, 32'hBBBB_B010, "R10");

    // R4/R5: four tags in set 5
    fill(20'h00015, 20'h10001);
    fill(20'h00025, 20'h10002);
    fill(20'h00035, 20'h10003);
    fill(20'h00045, 20'h10004);
    look(32'h0001_5000, 1, 32'h1000_1000, "R5");
    look(32'h0002_5004, 1, 32'h1000_2004, "R5");
    look(32'h0003_5008, 1, 32'h1000_3008, "R4");
    look(32'h0004_500C, 1, 32'h1000_400C, "R4");
    look(32'h0001_5010, 1, 32'h1000_1010, "R6");          // refresh tag 1
    // R6: fifth tag evicts least recently used (tag 2)
    fill(20'h00055, 20'h10005);
    look(32'h0002_5000, 0, '0, "R6");
    look(32'h0001_5000, 1, 32'h1000_1000, "R6");
    look(32'h0003_5000, 1, 32'h1000_3000, "R6");
    look(32'h0004_5000, 1, 32'h1000_4000, "R6");
    look(32'h0005_5000, 1, 32'h1000_5000, "R6");
    look(32'h0001_1000, 1, 32'hAAAA_A000, "R4");          // set 1 untouched

    // R7: refill of a stored page overwrites in place
    fill(20'h00017, 20'h20001);
    fill(20'h00017, 20'h20009);
    look(32'h0001_7000, 1, 32'h2000_9000, "R7");
    fill(20'h00027, 20'h20002);
    fill(20'h00037, 20'h20003);
    fill(20'h00047, 20'h20004);
    look(32'h0001_7000, 1, 32'h2000_9000, "R7");
    look(32'h0002_7000, 1, 32'h2000_2000, "R7");
    look(32'h0004_7000, 1, 32'h2000_4000, "R7");

    // R8: flush with lookup in the same cycle
    drive(1'b1, 32'h0001_5000, 1'b0, '0, '0, 1'b1, 0, '0, "R8");
    look(32'h0001_1000, 0, '0, "R8");
    look(32'h0001_7000, 0, '0, "R8");
    look(32'h0005_5000, 0, '0, "R8");

    // R9: fill during flush is dropped
    drive(1'b0, '0, 1'b1, 20'h00099, 20'h30000, 1'b1, 0, '0, "");
    look(32'h0009_9000, 0, '0, "R9");
    fill(20'h00099, 20'h30001);
    look(32'h0009_9123, 1, 32'h3000_1123, "R9");

    drive(1'b0, '0, 1'b0, '0, '0, 1'b0, 0, '0, "");
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule